// File: doc/BRIEF.md
# CBC Multi-Block Sequencer

This block chains a run of 128-bit blocks through cipher block chaining while they sit in a local block memory of 4096 entries. A run walks the memory upward from address 0 and works in place. Each block is read and combined with the chaining value where the direction calls for it. It is then handed to an external block transform over a request/acknowledge handshake, and the finished block is written back to the address it came from. The transform also receives the block's index and the direction, and it may take any number of cycles to answer.

A host loads and unloads the memory through a simple port while the sequencer is idle. The host then sets the direction, the chaining enable, the block count and the initial value, and pulses `start`. When chaining is enabled, the count gives the number of blocks to process, from 1 to 4095. When chaining is disabled, only block 0 is transformed and no combining is done. A count of zero makes the run an empty one.

Top module: `cbc_chain_seq`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done` and `xf_req` are low.
- R2: For encryption with chaining, block 0 becomes E(P0 xor IV, 0), and each later block i becomes E(Pi xor C(i-1), i). Here E(x, i) is the transform's answer for input x at index i, and C(i-1) is the ciphertext just written for block i-1.
- R3: For decryption with chaining, block i becomes D(Ci, i) xor V. V is the IV for block 0, and otherwise the ciphertext that block i-1 held before it was overwritten. Decrypting a run with the same IV and count restores the original plaintext.
- R4: Results land at the address they were read from. Addresses at or above the count keep their contents.
- R5: Transform requests carry `xf_index` equal to the block address, rising by one from 0 with no gaps, and `xf_decrypt` equal to the run's direction (1 = decrypt). A run with chaining issues exactly count requests.
- R6: Once `xf_req` is high, it stays high with `xf_data` and `xf_index` unchanged until a cycle in which `xf_ack` is high. `xf_result` is taken in that cycle.
- R7: With chaining disabled and a nonzero count, only block 0 is processed, with no combining. Block 0 becomes E(P0, 0) when encrypting or D(C0, 0) when decrypting, exactly one request is issued, and all other blocks are unchanged.
- R8: A start with a count of 0 issues no request and changes no block. `busy` stays low, and `done` is high in the cycle after the start edge.
- R9: `busy` is high from the cycle after a nonzero start until the final write. `done` is high for exactly one cycle after it, and `busy` is low while `done` is high.
- R10: A host write while idle stores `host_wdata` at `host_addr`. `host_rdata` shows the addressed block one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run, sampled while idle |
| decrypt | input | 1 | Run direction: 0 encrypt, 1 decrypt |
| chain_en | input | 1 | 1 chains over the count, 0 processes block 0 alone |
| blk_count | input | 12 | Number of blocks to process (0 = empty run) |
| iv | input | 128 | Initial chaining value |
| host_we | input | 1 | Host memory write strobe (acted on while idle) |
| host_addr | input | 12 | Host memory address |
| host_wdata | input | 128 | Host write data |
| host_rdata | output | 128 | Block read from memory, one cycle after the address |
| xf_req | output | 1 | Transform request |
| xf_decrypt | output | 1 | Direction passed to the transform |
| xf_index | output | 12 | Block index passed to the transform |
| xf_data | output | 128 | Block sent to the transform |
| xf_ack | input | 1 | Transform acknowledge, result valid |
| xf_result | input | 128 | Transformed block |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Memory reads through the host port return one cycle after the address is set, so the bench samples each read at the second falling edge after it drives the address. An empty run must show `done` at the first falling edge after the start edge. A nonzero run must show `busy` at that same edge. `done` is then watched for its single-cycle width, and the whole memory is compared only after the pulse. Each block needs four cycles plus the transform's wait, and the stub varies that wait between runs. For this reason the bench checks the order of requests and the final memory, and does not predict a total cycle count.

// File: rtl/cbc_seq_pkg.sv
package cbc_seq_pkg;

    localparam int BLK_W_DEF  = 128;
    localparam int ADDR_W_DEF = 12;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_LATCH = 3'd2,
        ST_REQ   = 3'd3,
        ST_WR    = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic dec;
        logic chain;
    } run_mode_t;

    function automatic logic state_active(seq_state_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/cbc_blk_mem.sv
module cbc_blk_mem
    import cbc_seq_pkg::*;
#(
    parameter int W  = BLK_W_DEF,
    parameter int AW = ADDR_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eng_own,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [W-1:0]  host_wdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [W-1:0]  eng_wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] addr;
    logic          we;
    logic [W-1:0]  wd;

    always_comb begin
        addr = eng_own ? eng_addr  : host_addr;
        we   = eng_own ? eng_we    : host_we;
        wd   = eng_own ? eng_wdata : host_wdata;
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wd;
        rdata <= mem[addr];
    end

    // R4: engine writes only go out while the engine owns the port
    p_eng_write_owned_r4: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> eng_own);

endmodule

// File: rtl/cbc_seq_ctrl.sv
module cbc_seq_ctrl
    import cbc_seq_pkg::*;
#(
    parameter int AW = ADDR_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  run_mode_t     mode_in,
    input  logic [AW-1:0] count,
    input  logic          xf_ack,
    output seq_state_e    state,
    output run_mode_t     mode_q,
    output logic [AW-1:0] idx,
    output logic          busy,
    output logic          done
);
    logic [AW-1:0] n_q;
    logic [AW-1:0] eff_count;
    logic          last;

    always_comb begin
        eff_count = mode_in.chain ? count : {{(AW-1){1'b0}}, |count};
        last      = (idx == n_q - AW'(1));
        busy      = state_active(state);
        done      = (state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            n_q    <= '0;
            mode_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    mode_q <= mode_in;
                    idx    <= '0;
                    n_q    <= eff_count;
                    state  <= (eff_count == '0) ? ST_DONE : ST_RD;
                end
                ST_RD:    state <= ST_LATCH;
                ST_LATCH: state <= ST_REQ;
                ST_REQ:   if (xf_ack) state <= ST_WR;
                ST_WR: begin
                    if (last) state <= ST_DONE;
                    else begin
                        idx   <= idx + AW'(1);
                        state <= ST_RD;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R8: an empty run goes straight to the end pulse
    p_empty_run_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && count == '0) |=> (state == ST_DONE));

    // R7: chaining off with a nonzero count runs exactly one block
    p_single_block_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && !mode_in.chain && count != '0) |=> (n_q == AW'(1)));

    // R4: the walk never leaves the counted range
    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < n_q));

    // R6: a write-back only follows an acknowledged request
    p_write_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR) |-> $past(xf_ack));

    // R9: the end pulse lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/cbc_chain_dp.sv
module cbc_chain_dp
    import cbc_seq_pkg::*;
#(
    parameter int W = BLK_W_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_iv,
    input  logic [W-1:0] iv,
    input  seq_state_e state,
    input  run_mode_t  mode_q,
    input  logic [W-1:0] rdata,
    input  logic       xf_ack,
    input  logic [W-1:0] xf_result,
    output logic [W-1:0] xf_data,
    output logic [W-1:0] wr_data
);
    logic [W-1:0] chain_q;
    logic [W-1:0] saved_ct;
    logic [W-1:0] mix;

    always_comb mix = mode_q.chain ? chain_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q  <= '0;
            saved_ct <= '0;
            xf_data  <= '0;
            wr_data  <= '0;
        end else begin
            if (load_iv) chain_q <= iv;
            if (state == ST_LATCH) begin
                saved_ct <= rdata;
                xf_data  <= mode_q.dec ? rdata : (rdata ^ mix);
            end
            if (state == ST_REQ && xf_ack) begin
                if (mode_q.dec) begin
                    wr_data <= xf_result ^ mix;
                    chain_q <= saved_ct;
                end else begin
                    wr_data <= xf_result;
                    chain_q <= xf_result;
                end
            end
        end
    end

    // R3: when decrypting, the chain advances to the block's own stored ciphertext
    p_dec_chain_src_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REQ && xf_ack && mode_q.dec) |=> (chain_q == $past(saved_ct)));

endmodule

// File: rtl/cbc_chain_seq.sv
module cbc_chain_seq
    import cbc_seq_pkg::*;
#(
    parameter int BLK_W  = BLK_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              decrypt,
    input  logic              chain_en,
    input  logic [ADDR_W-1:0] blk_count,
    input  logic [BLK_W-1:0]  iv,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BLK_W-1:0]  host_wdata,
    output logic [BLK_W-1:0]  host_rdata,
    output logic              xf_req,
    output logic              xf_decrypt,
    output logic [ADDR_W-1:0] xf_index,
    output logic [BLK_W-1:0]  xf_data,
    input  logic              xf_ack,
    input  logic [BLK_W-1:0]  xf_result,
    output logic              busy,
    output logic              done
);
    seq_state_e        state;
    run_mode_t         mode_in;
    run_mode_t         mode_q;
    logic [ADDR_W-1:0] idx;
    logic [BLK_W-1:0]  wr_data;
    logic [BLK_W-1:0]  rdata;
    logic              load_iv;

    always_comb begin
        mode_in.dec   = decrypt;
        mode_in.chain = chain_en;
        load_iv       = (state == ST_IDLE) && start;
        xf_req        = (state == ST_REQ);
        xf_decrypt    = mode_q.dec;
        xf_index      = idx;
        host_rdata    = rdata;
    end

    cbc_seq_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode_in (mode_in),
        .count   (blk_count),
        .xf_ack  (xf_ack),
        .state   (state),
        .mode_q  (mode_q),
        .idx     (idx),
        .busy    (busy),
        .done    (done)
    );

    cbc_chain_dp #(.W(BLK_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load_iv   (load_iv),
        .iv        (iv),
        .state     (state),
        .mode_q    (mode_q),
        .rdata     (rdata),
        .xf_ack    (xf_ack),
        .xf_result (xf_result),
        .xf_data   (xf_data),
        .wr_data   (wr_data)
    );

    cbc_blk_mem #(.W(BLK_W), .AW(ADDR_W)) u_mem (
        .clk        (clk),
        .rst        (rst),
        .eng_own    (busy),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .eng_we     (state == ST_WR),
        .eng_addr   (idx),
        .eng_wdata  (wr_data),
        .rdata      (rdata)
    );

    // R6: a pending request holds its payload until acknowledged
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (xf_req && !xf_ack) |=> (xf_req && $stable(xf_data) && $stable(xf_index)));

    // R9: the run ends with the end pulse and the port released
    p_busy_to_done_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> !done);

endmodule

// File: tb/cbc_chain_seq_bench.sv
module cbc_chain_seq_bench;
    localparam int W     = 128;
    localparam int AW    = 4;
    localparam int NB    = 1 << AW;
    localparam int LIMIT = 150000;
    localparam logic [W-1:0] KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, decrypt = 1'b0, chain_en = 1'b0;
    logic [AW-1:0] blk_count = '0;
    logic [W-1:0]  iv = '0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [W-1:0]  host_wdata = '0;
    logic [W-1:0]  host_rdata;
    logic          xf_req, xf_decrypt;
    logic [AW-1:0] xf_index;
    logic [W-1:0]  xf_data;
    logic          xf_ack = 1'b0;
    logic [W-1:0]  xf_result = '0;
    logic          busy, done;

    int n_checks = 0, n_fails = 0, cyc = 0;
    int ack_delay = 0, wcnt = 0, exp_idx = 0, req_seen = 0;
    logic run_dec = 1'b0;
    logic [W-1:0] orig [NB];
    logic [W-1:0] expv [NB];

    always #2.5 clk = ~clk;

    cbc_chain_seq #(.BLK_W(W), .ADDR_W(AW)) u_cbc_chain_seq (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .chain_en(chain_en),
        .blk_count(blk_count), .iv(iv), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .xf_req(xf_req),
        .xf_decrypt(xf_decrypt), .xf_index(xf_index), .xf_data(xf_data),
        .xf_ack(xf_ack), .xf_result(xf_result), .busy(busy), .done(done)
    );

    function automatic logic [W-1:0] rotl(logic [W-1:0] x, int n);
        return (n == 0) ? x : ((x << n) | (x >> (W - n)));
    endfunction
    function automatic logic [W-1:0] rotr(logic [W-1:0] x, int n);
        return (n == 0) ? x : ((x >> n) | (x << (W - n)));
    endfunction
    function automatic logic [W-1:0] f_enc(logic [W-1:0] x, int i);
        return rotl(x, (i * 5 + 1) % W) ^ KEY;
    endfunction
    function automatic logic [W-1:0] f_dec(logic [W-1:0] y, int i);
        return rotr(y ^ KEY, (i * 5 + 1) % W);
    endfunction
    function automatic logic [W-1:0] pat(int s, int i);
        logic [31:0] x;
        x = 32'(s) * 32'd2654435761 + 32'(i) * 32'd40503 + 32'd7;
        return {x, ~x, x ^ 32'hA5A5_5A5A, x + 32'(i)};
    endfunction

    task automatic chk(input string req, input logic ok, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // transform stub with a programmable wait, also checks request order
    initial begin
        forever begin
            @(negedge clk);
            if (xf_ack) xf_ack = 1'b0;
            else if (xf_req) begin
                if (wcnt >= ack_delay) begin
                    chk("R5 index", xf_index == AW'(exp_idx), W'(xf_index), W'(exp_idx));
                    chk("R5 direction", xf_decrypt == run_dec, W'(xf_decrypt), W'(run_dec));
                    xf_result = xf_decrypt ? f_dec(xf_data, int'(xf_index))
                                           : f_enc(xf_data, int'(xf_index));
                    xf_ack = 1'b1;
                    wcnt = 0;
                    exp_idx++;
                    req_seen++;
                end else wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic mem_write(input int a, input logic [W-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic mem_read(input int a, output logic [W-1:0] d);
        @(negedge clk);
        host_addr = AW'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic run(input logic dec, input logic ch, input int cnt, input logic [W-1:0] v, input int exp_reqs);
        @(negedge clk);
        decrypt = dec; chain_en = ch; blk_count = AW'(cnt); iv = v;
        run_dec = dec; exp_idx = 0; req_seen = 0; wcnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (exp_reqs == 0) begin
            chk("R8 done next cycle", done == 1'b1, W'(done), W'(1));
            chk("R8 busy low", busy == 1'b0, W'(busy), W'(0));
        end else begin
            chk("R9 busy after start", busy == 1'b1, W'(busy), W'(1));
            while (!done) @(negedge clk);
            chk("R9 busy low at done", busy == 1'b0, W'(busy), W'(0));
        end
        @(negedge clk);
        chk("R9 done one cycle", done == 1'b0, W'(done), W'(0));
        chk("R5 request count", req_seen == exp_reqs, W'(req_seen), W'(exp_reqs));
    endtask

    task automatic load_all(input int s);
        for (int i = 0; i < NB; i++) begin
            orig[i] = pat(s, i);
            mem_write(i, orig[i]);
        end
    endtask

    task automatic compare_all(input string req);
        logic [W-1:0] d;
        for (int i = 0; i < NB; i++) begin
            mem_read(i, d);
            chk(req, d == expv[i], d, expv[i]);
        end
    endtask

    initial begin
        logic [W-1:0] d, prev, v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy == 1'b0, W'(busy), W'(0));
        chk("R1 done", done == 1'b0, W'(done), W'(0));
        chk("R1 xf_req", xf_req == 1'b0, W'(xf_req), W'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {busy, done, xf_req} == 3'b000, W'({busy, done, xf_req}), W'(0));

        // R10: host port write and read-back
        mem_write(3, pat(99, 3));
        mem_read(3, d);
        chk("R10 host readback", d == pat(99, 3), d, pat(99, 3));

        // R2, R3, R4: sweep every nonzero count in both directions
        for (int n = 1; n < NB; n++) begin
            ack_delay = n % 3;
            v = pat(n + 500, 0);
            load_all(n);
            prev = v;
            for (int i = 0; i < NB; i++) begin
                if (i < n) begin
                    expv[i] = f_enc(orig[i] ^ prev, i);
                    prev = expv[i];
                end else expv[i] = orig[i];
            end
            run(1'b0, 1'b1, n, v, n);
            compare_all("R2/R4 encrypt chain");
            run(1'b1, 1'b1, n, v, n);
            for (int i = 0; i < NB; i++) expv[i] = orig[i];
            compare_all("R3/R4 decrypt restores");
        end

        // R3: decrypt a fresh pattern directly against the model
        ack_delay = 2;
        load_all(77);
        v = pat(78, 1);
        prev = v;
        for (int i = 0; i < NB; i++) begin
            if (i < 9) begin
                expv[i] = f_dec(orig[i], i) ^ prev;
                prev = orig[i];
            end else expv[i] = orig[i];
        end
        run(1'b1, 1'b1, 9, v, 9);
        compare_all("R3 decrypt model");

        // R8: empty run leaves memory alone
        load_all(200);
        for (int i = 0; i < NB; i++) expv[i] = orig[i];
        run(1'b0, 1'b1, 0, pat(1, 1), 0);
        compare_all("R8 memory unchanged");

        // R7: chaining off, encrypt then decrypt, count ignored beyond one block
        ack_delay = 1;
        load_all(300);
        for (int i = 0; i < NB; i++) expv[i] = orig[i];
        expv[0] = f_enc(orig[0], 0);
        run(1'b0, 1'b0, 6, pat(301, 0), 1);
        compare_all("R7 single encrypt");
        expv[0] = orig[0];
        run(1'b1, 1'b0, 11, pat(302, 0), 1);
        compare_all("R7 single decrypt");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule